// File: doc/BRIEF.md
# Flagged Integer ALU with Operand Comparator

This block is a purely combinational integer arithmetic/logic unit. It takes two operand words and a 4-bit operation code. It returns one result word of the operand width, which defaults to 32 bits. Results wider than the bus, such as a product, keep only their low bits.

Alongside the result it drives three status flags and a three-way compare of the operands.
- The zero flag reports an all-zero result.
- The negative flag reports the result sign, but only for the two subtraction codes.
- The overflow flag reports signed two's-complement overflow for additions and subtractions.

The compare outputs look only at the operands, never at the selected operation, so a caller gets an ordering in the same cycle as any arithmetic.

Operation codes:
- 0: a+b
- 1: a−b
- 2: b−a
- 3: a×b
- 4: a÷b
- 5: b mod a
- 6: ~a
- 7: a&b
- 8: a|b
- 9: a^b
- 10: a XNOR b
- 11: logical NOT of a
- 12: logical AND
- 13: logical OR
- 14 and 15: behave as code 0

Top module: `alu_flagged`

## Requirements
- R1: Code 0 gives a+b, code 1 gives a−b, code 2 gives b−a, code 3 gives the low word of a×b, code 4 gives unsigned a÷b, code 5 gives unsigned b mod a, and codes 14 and 15 give a+b, all modulo 2^W.
- R2: Code 6 gives ~a, code 7 gives a&b, code 8 gives a|b, code 9 gives a^b and code 10 gives ~(a^b).
- R3: Codes 11, 12 and 13 give a single truth bit in result bit 0 with all other bits 0. Code 11 is 1 only when a is all zeros. Code 12 is 1 when both words are nonzero. Code 13 is 1 when either word is nonzero.
- R4: Code 4 with b=0 and code 5 with a=0 return a result of all ones. In that case negative and overflow are 0.
- R5: zero is 1 exactly when every result bit is 0, for every code.
- R6: negative equals result bit W−1 when the code is 1 or 2, and is 0 for every other code.
- R7: For codes 0, 14 and 15, overflow is 1 exactly when a+b, read as signed, lies outside the signed W-bit range.
- R8: For code 1 (a−b) and code 2 (b−a), overflow is 1 exactly when the signed difference lies outside the signed W-bit range. For codes 3 to 13, overflow is 0.
- R9: lt, gt and eq compare a and b as unsigned numbers, independently of the code. Exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result, low word |
| zero | output | 1 | Result is all zeros |
| negative | output | 1 | Result sign, for subtraction codes only |
| overflow | output | 1 | Signed overflow of add or subtract |
| lt | output | 1 | a below b, unsigned |
| gt | output | 1 | a above b, unsigned |
| eq | output | 1 | a equal to b |

## Verification
Overflow and negative can be raised by the same subtraction. A difference that wraps can leave the sign bit either set or clear, and both cases must be reported correctly.

Directed vectors provoke each case:
- 0x7FFFFFFF minus 0xFFFFFFFF sets both flags.
- 0x80000000 minus 1 sets overflow but clears negative.

The same pairs are also applied in the reversed subtraction order, so the minuend's sign is chosen correctly. Each flag is judged against a bench model that widens the operands by one sign bit, independently of the other flag. The compare outputs are checked on the same vectors, since they too change in the cycle of any subtraction.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 4'd0,
        OP_SUB_AB = 4'd1,
        OP_SUB_BA = 4'd2,
        OP_MUL    = 4'd3,
        OP_DIV    = 4'd4,
        OP_MOD    = 4'd5,
        OP_NOT    = 4'd6,
        OP_AND    = 4'd7,
        OP_OR     = 4'd8,
        OP_XOR    = 4'd9,
        OP_XNOR   = 4'd10,
        OP_LNOT   = 4'd11,
        OP_LAND   = 4'd12,
        OP_LOR    = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } op_e;

    typedef struct packed {
        logic zero;
        logic negative;
        logic overflow;
    } status_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } order_t;

    // Codes that perform addition, including the spare codes.
    function automatic logic op_is_add(op_e op);
        return (op == OP_ADD) || (op == OP_RSV14) || (op == OP_RSV15);
    endfunction

    function automatic logic op_is_sub(op_e op);
        return (op == OP_SUB_AB) || (op == OP_SUB_BA);
    endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ZERO_W   = {W{1'b0}};

    logic a_nz, b_nz;
    assign a_nz = |a;
    assign b_nz = |b;

    always_comb begin
        case (op)
            OP_ADD:    result = a + b;
            OP_SUB_AB: result = a - b;
            OP_SUB_BA: result = b - a;
            OP_MUL:    result = a * b;
            OP_DIV:    result = b_nz ? (a / b) : ALL_ONES;
            OP_MOD:    result = a_nz ? (b % a) : ALL_ONES;
            OP_NOT:    result = ~a;
            OP_AND:    result = a & b;
            OP_OR:     result = a | b;
            OP_XOR:    result = a ^ b;
            OP_XNOR:   result = ~(a ^ b);
            OP_LNOT:   result = {ZERO_W[W-1:1], ~a_nz};
            OP_LAND:   result = {ZERO_W[W-1:1], a_nz & b_nz};
            OP_LOR:    result = {ZERO_W[W-1:1], a_nz | b_nz};
            default:   result = a + b;
        endcase
    end

    // R3: the logical codes leave every bit above bit 0 clear
    always_comb begin
        if (op == OP_LNOT || op == OP_LAND || op == OP_LOR)
            a_r3_logic_one_bit: assert (result[W-1:1] == ZERO_W[W-1:1]);
    end

endmodule

// File: rtl/alu_status.sv
module alu_status
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  logic [W-1:0] result,
    output status_t      status
);
    logic sa, sb, sr;
    assign sa = a[W-1];
    assign sb = b[W-1];
    assign sr = result[W-1];

    logic ovf;
    always_comb begin
        case (op)
            OP_SUB_AB: ovf = (sa != sb) && (sr != sa);
            OP_SUB_BA: ovf = (sb != sa) && (sr != sb);
            default:   ovf = op_is_add(op) && (sa == sb) && (sr != sa);
        endcase
    end

    assign status.zero     = ~(|result);
    assign status.negative = sr & op_is_sub(op);
    assign status.overflow = ovf;

    // R7: a wrapped addition flips the sign of the shared operand sign
    always_comb begin
        if (op_is_add(op) && status.overflow)
            a_r7_add_sign_flip: assert (sa == sb && sr != sa);
    end

endmodule

// File: rtl/alu_order.sv
module alu_order
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output order_t       order
);
    assign order.lt = a < b;
    assign order.gt = a > b;
    assign order.eq = a == b;

    // R9: exactly one ordering output is set
    always_comb begin
        a_r9_one_order: assert ($countones({order.lt, order.gt, order.eq}) == 1);
    end

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]  result,
    output logic          zero,
    output logic          negative,
    output logic          overflow,
    output logic          lt,
    output logic          gt,
    output logic          eq
);
    op_e     op_q;
    status_t st;
    order_t  ord;

    assign op_q = op_e'(op);

    alu_datapath #(.W(W)) u_path (
        .a(a), .b(b), .op(op_q), .result(result)
    );

    alu_status #(.W(W)) u_stat (
        .a(a), .b(b), .op(op_q), .result(result), .status(st)
    );

    alu_order #(.W(W)) u_ord (
        .a(a), .b(b), .order(ord)
    );

    assign zero     = st.zero;
    assign negative = st.negative;
    assign overflow = st.overflow;
    assign lt       = ord.lt;
    assign gt       = ord.gt;
    assign eq       = ord.eq;

    always_comb begin
        // R5: a-b is zero exactly when the comparator reports equality
        if (op_q == OP_SUB_AB)
            a_r5_zero_matches_eq: assert (zero == eq);
        // R4: division by zero yields all ones with no flag raised
        if ((op_q == OP_DIV && !(|b)) || (op_q == OP_MOD && !(|a)))
            a_r4_div_zero_ones: assert ((&result) && !negative && !overflow);
        // R6: negative is confined to the subtraction codes
        if (!(op_q == OP_SUB_AB || op_q == OP_SUB_BA))
            a_r6_neg_gated: assert (!negative);
        // R8: overflow is confined to add and subtract codes
        if (op_q inside {OP_MUL, OP_DIV, OP_MOD, OP_NOT, OP_AND, OP_OR,
                         OP_XOR, OP_XNOR, OP_LNOT, OP_LAND, OP_LOR})
            a_r8_no_overflow: assert (!overflow);
    end

endmodule

// File: tb/tb_alu_flagged.sv
module tb_alu_flagged;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] a, b, result;
    logic [3:0]  op;
    logic zero, negative, overflow, lt, gt, eq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    alu_flagged dut (
        .a(a), .b(b), .op(op), .result(result), .zero(zero),
        .negative(negative), .overflow(overflow), .lt(lt), .gt(gt), .eq(eq)
    );

    function automatic logic [31:0] m_result(logic [3:0] o, logic [31:0] x, logic [31:0] y);
        logic [63:0] p;
        case (o)
            4'd1:  return x - y;
            4'd2:  return y - x;
            4'd3:  begin p = {32'd0, x} * {32'd0, y}; return p[31:0]; end
            4'd4:  return (y == 0) ? 32'hFFFF_FFFF : x / y;
            4'd5:  return (x == 0) ? 32'hFFFF_FFFF : y % x;
            4'd6:  return ~x;
            4'd7:  return x & y;
            4'd8:  return x | y;
            4'd9:  return x ^ y;
            4'd10: return x ^~ y;
            4'd11: return (x == 0) ? 32'd1 : 32'd0;
            4'd12: return (x != 0 && y != 0) ? 32'd1 : 32'd0;
            4'd13: return (x != 0 || y != 0) ? 32'd1 : 32'd0;
            default: return x + y;
        endcase
    endfunction

    function automatic logic m_ovf(logic [3:0] o, logic [31:0] x, logic [31:0] y);
        logic [32:0] wx, wy, s;
        wx = {x[31], x};
        wy = {y[31], y};
        case (o)
            4'd1: s = wx - wy;
            4'd2: s = wy - wx;
            4'd0, 4'd14, 4'd15: s = wx + wy;
            default: return 1'b0;
        endcase
        return s[32] != s[31];
    endfunction

    function automatic string req_of(logic [3:0] o, logic [31:0] x, logic [31:0] y);
        if ((o == 4'd4 && y == 0) || (o == 4'd5 && x == 0)) return "R4";
        if (o >= 4'd6 && o <= 4'd10) return "R2";
        if (o >= 4'd11 && o <= 4'd13) return "R3";
        return "R1";
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s op=%0d a=%h b=%h: actual %h expected %h",
                     req, what, op, a, b, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] o, logic [31:0] x, logic [31:0] y);
        logic [31:0] er;
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        er = m_result(o, x, y);
        chk(req_of(o, x, y), "result", result, er);
        chk("R5", "zero", {31'd0, zero}, {31'd0, er == 0});
        chk("R6", "negative", {31'd0, negative},
            {31'd0, er[31] && (o == 4'd1 || o == 4'd2)});
        chk((o == 4'd1 || o == 4'd2) ? "R8" : "R7", "overflow",
            {31'd0, overflow}, {31'd0, m_ovf(o, x, y)});
        chk("R9", "order", {29'd0, lt, gt, eq}, {29'd0, x < y, x > y, x == y});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [5];
        corners = '{32'd0, 32'd1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
        void'($urandom(32'd20151206));
        op = 4'd0; a = 0; b = 0;
        // Idle inputs: zero flag and equality (R5, R9)
        apply(4'd0, 32'd0, 32'd0);
        // Overflow and negative together on subtraction (R6, R8)
        apply(4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply(4'd1, 32'h8000_0000, 32'd1);
        apply(4'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
        apply(4'd2, 32'd1, 32'h8000_0000);
        // Add overflow both directions (R7), spare codes (R1)
        apply(4'd0, 32'h7FFF_FFFF, 32'd1);
        apply(4'd14, 32'h8000_0000, 32'hFFFF_FFFF);
        apply(4'd15, 32'd5, 32'd7);
        // Divide and modulo by zero (R4)
        apply(4'd4, 32'd123, 32'd0);
        apply(4'd5, 32'd0, 32'd99);
        // Multiply truncation, no overflow (R1, R8)
        apply(4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // Logical codes (R3)
        apply(4'd11, 32'd0, 32'd0);
        apply(4'd12, 32'h8000_0000, 32'd0);
        apply(4'd13, 32'd0, 32'd2);
        // All opcodes over all corner pairs
        for (int o = 0; o < 16; o++)
            foreach (corners[i])
                foreach (corners[j])
                    apply(o[3:0], corners[i], corners[j]);
        // Constrained random
        for (int k = 0; k < 3000; k++)
            apply(4'($urandom_range(0, 15)), pick(), pick());
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule